// File: doc/BRIEF.md
# Access-Delay Acknowledge Timer

This block paces the transfer acknowledge of a read-only memory region on a shared bus. When the address decoder flags that the current access falls in a populated ROM socket, the block starts a small counter on the bus clock. It pulls the active-low acknowledge once the counter reaches a terminal value. The terminal value is a 4-bit access-time code when no RAM shares the addressed region. When RAM does overlap the region, the terminal value is fixed at the top count of the counter. This leaves a dynamic RAM on the same addresses enough time to finish a refresh it had already started.

For the whole time the block is serving a read, it also drives an active-low RAM inhibit so that any overlapped RAM keeps off the data bus. The acknowledge line is only driven while module select is true, which is shown through a separate output-enable. Any of four conditions stops and restarts the timing: the read command being removed, the inhibit-ROM input becoming active, module select falling, or a change of the address that produced module select. Address decoding and data steering sit outside this block.

Top module: `ack_delay_timer`

## Requirements
- R1: After a synchronous reset with module select low, ack_oe is 0, ack_n is 1 and ram_inh_n is 1.
- R2: The access counter is zero whenever the access is not live, where live means sel=1, rd_cmd=1, rom_block=0 and addr_chg=0. While live and short of the terminal value, it rises by one on each clock edge.
- R3: With ram_overlap=0, ack_n goes low after exactly as many clock edges as the unsigned value of ack_code (0 to 15) since the access became live. Code 0 acknowledges at once.
- R4: With ram_overlap=1, ack_n goes low after exactly 15 clock edges whatever ack_code holds. A change of ack_code during the access has no effect on that latency.
- R5: Once the terminal value is reached, the counter stops advancing, and ack_n stays low for as long as the access stays live.
- R6: ram_inh_n is low whenever sel=1, rd_cmd=1 and rom_block=0. This includes every cycle while the acknowledge is low and a cycle in which addr_chg is high. ram_inh_n is high otherwise.
- R7: Dropping rd_cmd, raising rom_block, raising addr_chg or dropping sel for one clock edge forces ack_n high in that cycle and restarts the count from zero. The next acknowledge then needs the full latency again.
- R8: ack_oe equals sel. While sel=1, ack_n is high unless the access is live and the counter has reached its terminal value.
- R9: While rom_block=1, the block issues neither an acknowledge nor a RAM inhibit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; one count per rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| sel | input | 1 | Module select from the address decoder |
| rd_cmd | input | 1 | Memory read command, active high |
| rom_block | input | 1 | Inhibit-ROM request from another module, active high |
| addr_chg | input | 1 | Pulse: the address behind sel has changed |
| ack_code | input | 4 | Access-time code used when no RAM is overlapped |
| ram_overlap | input | 1 | Decoded region is shared with RAM |
| ack_n | output | 1 | Transfer acknowledge, active low |
| ack_oe | output | 1 | Drive enable for ack_n |
| ram_inh_n | output | 1 | RAM inhibit, active low |

## Verification
The bench sweeps every access-time code with and without RAM overlap and records the exact edge on which the acknowledge first falls. An off-by-one compare, a counter that wraps, or an overlap path that still reads the code would all show up as a latency that misses by one or more edges. Each clear source is applied halfway through a count, and the bench then measures the full latency again: a clear that only freezes the counter would acknowledge early. It also checks that the inhibit stays asserted across an address change and while the acknowledge is held. A design that tied the inhibit to the counter would release the RAM too soon.

// File: rtl/adt_pkg.sv
// Shared definitions for the access-delay acknowledge timer.
// Assumes a counter width of at least two bits.
package adt_pkg;
    parameter int CNT_W = 4;
    typedef logic [CNT_W-1:0] cnt_t;
    typedef enum logic {
        LIMIT_CODE  = 1'b0,
        LIMIT_FIXED = 1'b1
    } limit_src_e;
endpackage

// File: rtl/adt_qualify.sv
// Access qualifier: decides whether the current access is live, and
// whether the RAM inhibit is requested. Assumes all inputs are
// synchronous to clk.
module adt_qualify (
    input  logic clk,
    input  logic rst_n,
    input  logic sel,
    input  logic rd_cmd,
    input  logic rom_block,
    input  logic addr_chg,
    output logic live,
    output logic inh_req
);
    // Inhibit is requested for a selected, unblocked read.
    always_comb inh_req = sel & rd_cmd & ~rom_block;

    // An address change clears the timing but leaves the inhibit in place.
    always_comb live = inh_req & ~addr_chg;

    // R9
    rom_block_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rom_block |-> (!inh_req && !live));
endmodule

// File: rtl/adt_limit.sv
// Terminal-value select: the programmed code, or the fixed top count
// when RAM overlaps the region.
module adt_limit
    import adt_pkg::*;
#(
    parameter int W = CNT_W
) (
    input  logic [W-1:0] code,
    input  logic         overlap,
    output logic [W-1:0] limit
);
    localparam logic [W-1:0] FIXED_TOP = {W{1'b1}};

    limit_src_e src;

    // Choose the source of the terminal value.
    always_comb src = overlap ? LIMIT_FIXED : LIMIT_CODE;

    // Drive the terminal value from the chosen source.
    always_comb begin
        case (src)
            LIMIT_FIXED: limit = FIXED_TOP;
            default:     limit = code;
        endcase
    end
endmodule

// File: rtl/adt_counter.sv
// Access counter: held at zero while the access is not live, counts
// one per clock while live, and stops at the terminal value.
// Assumes the terminal value is stable during an access.
module adt_counter #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         live,
    input  logic [W-1:0] limit,
    output logic         at_limit
);
    logic [W-1:0] cnt;

    // Terminal condition seen on the current count.
    always_comb at_limit = live && (cnt == limit);

    // Count, hold or clear.
    always_ff @(posedge clk) begin
        if (!rst_n || !live)
            cnt <= '0;
        else if (!at_limit)
            cnt <= cnt + 1'b1;
    end

    // R2
    cnt_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !live |=> (cnt == '0));
    // R2
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (live && !at_limit) |=> (cnt == $past(cnt) + 1'b1));
    // R5
    cnt_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (live && at_limit) |=> (cnt == $past(cnt)));
endmodule

// File: rtl/adt_drive.sv
// Output stage: active-low acknowledge with its drive enable, and the
// active-low RAM inhibit.
module adt_drive (
    input  logic clk,
    input  logic rst_n,
    input  logic sel,
    input  logic at_limit,
    input  logic inh_req,
    output logic ack_n,
    output logic ack_oe,
    output logic ram_inh_n
);
    // Acknowledge is driven only while selected; high until terminal.
    always_comb begin
        ack_oe    = sel;
        ack_n     = ~(sel & at_limit);
        ram_inh_n = ~inh_req;
    end

    // R6
    inh_covers_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ack_n |-> !ram_inh_n);
    // R8
    oe_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sel |-> (!ack_oe && ack_n));
endmodule

// File: rtl/ack_delay_timer.sv
// Access-delay acknowledge timer top: qualifies the access, selects the
// terminal value from the overlap flag, runs the counter and drives the
// acknowledge and RAM inhibit.
module ack_delay_timer
    import adt_pkg::*;
#(
    parameter int W = CNT_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         sel,
    input  logic         rd_cmd,
    input  logic         rom_block,
    input  logic         addr_chg,
    input  logic [W-1:0] ack_code,
    input  logic         ram_overlap,
    output logic         ack_n,
    output logic         ack_oe,
    output logic         ram_inh_n
);
    logic         live;
    logic         inh_req;
    logic         at_limit;
    logic [W-1:0] limit;

    adt_qualify u_qual (
        .clk(clk), .rst_n(rst_n), .sel(sel), .rd_cmd(rd_cmd),
        .rom_block(rom_block), .addr_chg(addr_chg),
        .live(live), .inh_req(inh_req)
    );

    adt_limit #(.W(W)) u_limit (
        .code(ack_code), .overlap(ram_overlap), .limit(limit)
    );

    adt_counter #(.W(W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .live(live), .limit(limit),
        .at_limit(at_limit)
    );

    adt_drive u_drive (
        .clk(clk), .rst_n(rst_n), .sel(sel), .at_limit(at_limit),
        .inh_req(inh_req), .ack_n(ack_n), .ack_oe(ack_oe),
        .ram_inh_n(ram_inh_n)
    );

    // R7
    clear_drops_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_chg || !rd_cmd) |-> ack_n);
endmodule

// File: tb/sim_ack_delay_timer.sv
module sim_ack_delay_timer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sel = 1'b0, rd_cmd = 1'b0, rom_block = 1'b0, addr_chg = 1'b0;
    logic [3:0] ack_code = 4'd0;
    logic       ram_overlap = 1'b0;
    logic       ack_n, ack_oe, ram_inh_n;
    int         n_chk = 0, n_fail = 0;
    bit         finished = 1'b0;

    always #2.5 clk = ~clk;

    ack_delay_timer u0 (
        .clk(clk), .rst_n(rst_n), .sel(sel), .rd_cmd(rd_cmd),
        .rom_block(rom_block), .addr_chg(addr_chg), .ack_code(ack_code),
        .ram_overlap(ram_overlap), .ack_n(ack_n), .ack_oe(ack_oe),
        .ram_inh_n(ram_inh_n)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Go idle and let the counter clear.
    task automatic idle();
        @(negedge clk);
        sel = 0; rd_cmd = 0; rom_block = 0; addr_chg = 0;
        @(negedge clk);
    endtask

    // Edges until ack_n first falls, sampled at negedges; -1 if never.
    task automatic measure(input int max_k, output int got, output bit inh_bad);
        got = -1; inh_bad = 0;
        #1;
        for (int k = 0; k <= max_k; k++) begin
            if (k > 0) begin @(negedge clk); #1; end
            if (!ack_n && got < 0) got = k;
            if (ram_inh_n) inh_bad = 1;
        end
    endtask

    task automatic t_reset();
        #1;
        chk("R1 ack_oe", ack_oe, 0);
        chk("R1 ack_n", ack_n, 1);
        chk("R1 ram_inh_n", ram_inh_n, 1);
    endtask

    // R3 / R4 latency, R5 hold, R6 inhibit, R8 release.
    task automatic t_latency(input int code, input bit ov);
        int got; bit bad; int exp;
        exp = ov ? 15 : code;
        @(negedge clk);
        sel = 1; rd_cmd = 1; ack_code = code[3:0]; ram_overlap = ov;
        measure(exp, got, bad);
        chk(ov ? "R4 overlap latency" : "R3 code latency", got, exp);
        chk("R6 inhibit held", int'(bad), 0);
        repeat (3) @(negedge clk);
        #1;
        chk("R5 ack held", ack_n, 0);
        @(negedge clk);
        sel = 0; rd_cmd = 0;
        #1;
        chk("R8 oe released", ack_oe, 0);
        chk("R6 inhibit released", ram_inh_n, 1);
        @(negedge clk);
    endtask

    // R4: changing the code mid-access under overlap does nothing.
    task automatic t_overlap_code_change();
        int got; bit bad;
        @(negedge clk);
        sel = 1; rd_cmd = 1; ack_code = 4'd3; ram_overlap = 1;
        @(negedge clk); @(negedge clk);
        ack_code = 4'd5;
        measure(14, got, bad);
        chk("R4 code change ignored", got, 13);
        idle();
        ram_overlap = 0;
    endtask

    // R7 / R9: clear sources 0=read off, 1=rom_block, 2=addr_chg, 3=sel off.
    task automatic t_clear(input int src);
        int got; bit bad;
        @(negedge clk);
        sel = 1; rd_cmd = 1; ack_code = 4'd10; ram_overlap = 0;
        repeat (5) @(negedge clk);
        case (src)
            0: rd_cmd = 0;
            1: rom_block = 1;
            2: addr_chg = 1;
            default: sel = 0;
        endcase
        #1;
        chk("R7 ack high while clearing", ack_n, 1);
        if (src == 2) chk("R6 inhibit kept on address change", ram_inh_n, 0);
        else          chk("R9 R7 inhibit dropped", ram_inh_n, 1);
        @(negedge clk);
        sel = 1; rd_cmd = 1; rom_block = 0; addr_chg = 0;
        measure(12, got, bad);
        chk("R7 full latency after clear", got, 10);
        idle();
    endtask

    // R9: rom_block held for a long time gives no acknowledge.
    task automatic t_block_hold();
        int lows = 0;
        @(negedge clk);
        sel = 1; rd_cmd = 1; rom_block = 1; ack_code = 4'd2;
        for (int k = 0; k < 6; k++) begin
            @(negedge clk); #1;
            if (!ack_n || !ram_inh_n) lows++;
        end
        chk("R9 no ack or inhibit while blocked", lows, 0);
        idle();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1;
        @(negedge clk);
        for (int c = 0; c < 16; c++) begin
            t_latency(c, 1'b0);
            t_latency(c, 1'b1);
        end
        t_overlap_code_change();
        for (int s = 0; s < 4; s++) t_clear(s);
        t_block_hold();
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule